// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This controller decides how a processor core moves into, between and out of exception handlers. Requests are set into a pending register by one-cycle pulses, and each request carries a static numeric priority. To enter a handler from idle, the block saves an 8-word context frame through a stack-memory port, one word per accepted handshake. It then announces the chosen handler with a one-cycle start strobe. When a handler finishes, the block either restores the frame with eight pops, or it starts the next pending handler at once on the frame that is already saved.

Two shortcuts avoid wasted stack traffic. In the first, a more urgent request can take over a frame save that is still running. The save goes on unchanged, and the urgent handler starts first on that frame. In the second, when a handler ends while another request qualifies, that request is started without a pop/push pair. A request that arrives once a handler is running preempts it in the usual way: another frame is pushed and the nesting depth rises. The number of the preempted exception is kept on a 4-entry return stack, so the block can resume it later.

Top module: `exc_seq`

## Requirements
- R1: After reset, pushReq, popReq, handlerStart and activeValid are 0 and depth is 0.
- R2: From idle, a pending request starts a save of FRAME_WORDS (8) words. pushReq stays high, and wordIdx counts 0,1,…,7, advancing only on a cycle with stackDone high. Without stackDone, wordIdx holds.
- R3: In the cycle after the last push is accepted, handlerStart is 1 for exactly one cycle, activeExc shows the chosen exception and depth has risen by one. The chosen exception's pending bit is cleared.
- R4: Selection picks the pending request with the lowest numeric priority value. Among equal values, the lowest exception number wins.
- R5: While a handler runs, a pending request whose priority value is equal to or larger than the active one causes no push and leaves activeExc and depth unchanged.
- R6: While a handler runs, a pending request with a strictly lower priority value preempts it. A new 8-word frame is pushed, depth rises by one, and the new handler starts.
- R7: If a more urgent request becomes pending during a frame save, and a non-final word of that save is still accepted after it becomes pending, the save continues without restarting. The urgent request is the one started, and the originally chosen request stays pending.
- R8: A request that becomes pending only in the cycle of the last push acceptance, or later, does not redirect the save. It preempts the started handler as in R6.
- R9: On handlerDone, a pending request that beats the level being returned to (any pending request at depth 1) is started without popping. handlerStart rises two cycles after handlerDone is sampled, and depth is unchanged.
- R10: On handlerDone with no qualifying request, 8 pops are issued with wordIdx 7 down to 0. At depth 1 the block returns to idle with depth 0. Deeper, it resumes the preempted exception with depth reduced by one and no handlerStart.
- R11: At depth RET_DEPTH (4), no further preemption occurs. A more urgent request stays pending.
- R12: activeValid is 1 only while a handler is running. It is 0 while idle, during a save, during a restore and in the chaining cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqSet | input | NUM_EXC | One-cycle pulses that set pending bits |
| reqPrio | input | NUM_EXC*PRIO_W | Priority of exception i in bits [i*PRIO_W +: PRIO_W]; lower value is more urgent |
| handlerDone | input | 1 | Running handler has finished |
| stackDone | input | 1 | Stack port accepts the current push or pop word |
| pushReq | output | 1 | Request to push the word at wordIdx |
| popReq | output | 1 | Request to pop the word at wordIdx |
| wordIdx | output | $clog2(FRAME_WORDS) | Frame word offset of the current stack request |
| activeExc | output | $clog2(NUM_EXC) | Number of the current exception |
| activeValid | output | 1 | A handler is running |
| handlerStart | output | 1 | One-cycle strobe when a handler begins |
| depth | output | $clog2(RET_DEPTH+1) | Number of frames on the stack |

## Verification
Several rules are checked by the assertions on every cycle. These are: the push request holding its word while unacknowledged, the start strobe lasting one cycle, the clearing of a taken request's pending bit, the depth bound, and the absence of a pop after a chaining decision. A further assertion holds each handler taken by nesting to a strictly better priority than the exception it displaced. The exact point where a late arrival stops redirecting a save can only be shown by bench scenarios, because it depends on when the request lands against the word count. The same holds for tie-breaking, for which exception is started after a frame is reused, and for resuming the right handler after a restore.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STACK,
    ST_HANDLER,
    ST_CHAIN,
    ST_UNSTACK
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTarget;
    logic retarget;
    logic take;
    logic pushRet;
    logic popRet;
    logic incDepth;
    logic decDepth;
  } seqStrb_t;

  // decisions from datapath to control
  typedef struct packed {
    logic haveBest;
    logic preemptOk;
    logic chainOk;
    logic lastLevel;
  } seqFlag_t;

endpackage

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int NUM_EXC   = 8,
  parameter int PRIO_W    = 3,
  parameter int RET_DEPTH = 4,
  localparam int EXC_W    = $clog2(NUM_EXC),
  localparam int DEP_W    = $clog2(RET_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_EXC-1:0]        reqSet,
  input  logic [NUM_EXC*PRIO_W-1:0] reqPrio,
  input  seqStrb_t                  strb,
  output seqFlag_t                  flags,
  output logic [EXC_W-1:0]          activeExc,
  output logic [DEP_W-1:0]          depth
);

  localparam int RS_W = (RET_DEPTH > 1) ? $clog2(RET_DEPTH) : 1;

  logic [PRIO_W-1:0] prioArr [NUM_EXC];
  logic [NUM_EXC-1:0] pend;
  logic [NUM_EXC-1:0] clrMask;
  logic [EXC_W-1:0]  target;
  logic [EXC_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic              haveBest;
  logic              lateBetter;
  logic [EXC_W-1:0]  retStk [RET_DEPTH];
  logic [RS_W-1:0]   topIdx;
  logic [RS_W-1:0]   underIdx;
  logic [PRIO_W-1:0] activePrio;
  logic [PRIO_W-1:0] targetPrio;
  logic [PRIO_W-1:0] retPrio;

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_prio
    assign prioArr[g] = reqPrio[g*PRIO_W +: PRIO_W];
  end

  // arbiter: lowest value, ties to lowest number (strict compare)
  always_comb begin
    haveBest = 1'b0;
    bestIdx  = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM_EXC; i++) begin
      if (pend[i] && (!haveBest || prioArr[i] < bestPrio)) begin
        haveBest = 1'b1;
        bestIdx  = EXC_W'(i);
        bestPrio = prioArr[i];
      end
    end
  end

  assign topIdx     = RS_W'(depth - DEP_W'(1));
  assign underIdx   = RS_W'(depth - DEP_W'(2));
  assign activePrio = prioArr[activeExc];
  assign targetPrio = prioArr[target];
  assign retPrio    = prioArr[retStk[underIdx]];
  assign lateBetter = haveBest && (bestPrio < targetPrio);

  assign flags.haveBest  = haveBest;
  assign flags.preemptOk = haveBest && (bestPrio < activePrio) && (depth < DEP_W'(RET_DEPTH));
  assign flags.chainOk   = haveBest && ((depth < DEP_W'(2)) || (bestPrio < retPrio));
  assign flags.lastLevel = (depth == DEP_W'(1));

  assign clrMask = strb.take ? (NUM_EXC'(1) << target) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= '0;
      target    <= '0;
      activeExc <= '0;
      depth     <= '0;
    end else begin
      pend <= (pend & ~clrMask) | reqSet;
      if (strb.loadTarget || (strb.retarget && lateBetter)) target <= bestIdx;
      if (strb.take)        activeExc <= target;
      else if (strb.popRet) activeExc <= retStk[underIdx];
      if (strb.incDepth)      depth <= depth + DEP_W'(1);
      else if (strb.decDepth) depth <= depth - DEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < RET_DEPTH; j++) retStk[j] <= '0;
    end else if (strb.pushRet) begin
      retStk[topIdx] <= activeExc;
    end
  end

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEP_W'(RET_DEPTH));

  // R3
  take_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && !reqSet[target]) |=> !pend[$past(target)]);

  // R6
  nest_better_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && strb.incDepth && depth != '0) |-> (targetPrio < prioArr[retStk[topIdx]]));

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
#(
  parameter int FRAME_WORDS = 8,
  localparam int WRD_W      = $clog2(FRAME_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             handlerDone,
  input  logic             stackDone,
  input  seqFlag_t         flags,
  output seqStrb_t         strb,
  output logic             pushReq,
  output logic             popReq,
  output logic [WRD_W-1:0] wordIdx,
  output logic             handlerStart,
  output logic             inHandler
);

  seqState_e        state, nextState;
  logic [WRD_W-1:0] wordCnt;
  logic             lastWord;
  logic             accept;
  logic             startNext;

  assign lastWord  = (wordCnt == WRD_W'(FRAME_WORDS - 1));
  assign pushReq   = (state == ST_STACK);
  assign popReq    = (state == ST_UNSTACK);
  assign inHandler = (state == ST_HANDLER);
  assign accept    = (pushReq || popReq) && stackDone;
  assign wordIdx   = popReq ? (WRD_W'(FRAME_WORDS - 1) - wordCnt) : wordCnt;

  always_comb begin
    strb      = '0;
    nextState = state;
    startNext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (flags.haveBest) begin
          strb.loadTarget = 1'b1;
          nextState       = ST_STACK;
        end
      end
      ST_STACK: begin
        strb.retarget = !(stackDone && lastWord);
        if (stackDone && lastWord) begin
          strb.take     = 1'b1;
          strb.incDepth = 1'b1;
          startNext     = 1'b1;
          nextState     = ST_HANDLER;
        end
      end
      ST_HANDLER: begin
        if (handlerDone) begin
          if (flags.chainOk) begin
            strb.loadTarget = 1'b1;
            nextState       = ST_CHAIN;
          end else begin
            nextState = ST_UNSTACK;
          end
        end else if (flags.preemptOk) begin
          strb.pushRet    = 1'b1;
          strb.loadTarget = 1'b1;
          nextState       = ST_STACK;
        end
      end
      ST_CHAIN: begin
        strb.take = 1'b1;
        startNext = 1'b1;
        nextState = ST_HANDLER;
      end
      ST_UNSTACK: begin
        if (stackDone && lastWord) begin
          strb.decDepth = 1'b1;
          if (flags.lastLevel) begin
            nextState = ST_IDLE;
          end else begin
            strb.popRet = 1'b1;
            nextState   = ST_HANDLER;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      wordCnt      <= '0;
      handlerStart <= 1'b0;
    end else begin
      state        <= nextState;
      handlerStart <= startNext;
      if (state != nextState) wordCnt <= '0;
      else if (accept)        wordCnt <= wordCnt + WRD_W'(1);
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !stackDone) |=> (pushReq && $stable(wordIdx)));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    handlerStart |=> !handlerStart);

  // R9
  chain_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inHandler && handlerDone && flags.chainOk) |=> !popReq ##1 handlerStart);

  // R10
  unstack_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && stackDone && wordIdx == '0 && flags.lastLevel) |=> (state == ST_IDLE));

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_seq_pkg::*;
#(
  parameter int NUM_EXC     = 8,
  parameter int PRIO_W      = 3,
  parameter int RET_DEPTH   = 4,
  parameter int FRAME_WORDS = 8,
  localparam int EXC_W      = $clog2(NUM_EXC),
  localparam int DEP_W      = $clog2(RET_DEPTH + 1),
  localparam int WRD_W      = $clog2(FRAME_WORDS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_EXC-1:0]        reqSet,
  input  logic [NUM_EXC*PRIO_W-1:0] reqPrio,
  input  logic                      handlerDone,
  input  logic                      stackDone,
  output logic                      pushReq,
  output logic                      popReq,
  output logic [WRD_W-1:0]          wordIdx,
  output logic [EXC_W-1:0]          activeExc,
  output logic                      activeValid,
  output logic                      handlerStart,
  output logic [DEP_W-1:0]          depth
);

  seqStrb_t strb;
  seqFlag_t flags;

  exc_seq_ctrl #(
    .FRAME_WORDS(FRAME_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .handlerDone (handlerDone),
    .stackDone   (stackDone),
    .flags       (flags),
    .strb        (strb),
    .pushReq     (pushReq),
    .popReq      (popReq),
    .wordIdx     (wordIdx),
    .handlerStart(handlerStart),
    .inHandler   (activeValid)
  );

  exc_seq_dp #(
    .NUM_EXC  (NUM_EXC),
    .PRIO_W   (PRIO_W),
    .RET_DEPTH(RET_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqSet   (reqSet),
    .reqPrio  (reqPrio),
    .strb     (strb),
    .flags    (flags),
    .activeExc(activeExc),
    .depth    (depth)
  );

endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  reqSet = '0;
  logic [23:0] reqPrio = '0;
  logic        handlerDone = 1'b0;
  logic        stackDone = 1'b0;
  logic        pushReq, popReq, activeValid, handlerStart;
  logic [2:0]  wordIdx, activeExc, depth;

  int nChk = 0;
  int nBad = 0;

  localparam int DEF_PRIO [8] = '{4, 2, 6, 2, 1, 5, 0, 3};
  // {request mask, expected winner}
  localparam logic [10:0] VECS [8] = '{
    {8'h01, 3'd0}, {8'h05, 3'd0}, {8'h0A, 3'd1}, {8'h12, 3'd4},
    {8'hFF, 3'd6}, {8'hA0, 3'd7}, {8'h28, 3'd3}, {8'h0C, 3'd3}
  };

  always #4 clk = ~clk;

  exc_seq uut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .reqPrio(reqPrio),
    .handlerDone(handlerDone), .stackDone(stackDone),
    .pushReq(pushReq), .popReq(popReq), .wordIdx(wordIdx),
    .activeExc(activeExc), .activeValid(activeValid),
    .handlerStart(handlerStart), .depth(depth)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic setPrio(input bit reversed);
    for (int i = 0; i < 8; i++)
      reqPrio[i*3 +: 3] = reversed ? 3'(7 - i) : 3'(DEF_PRIO[i]);
  endtask

  task automatic doReset;
    rstN = 1'b0; reqSet = '0; handlerDone = 1'b0; stackDone = 1'b0;
    tick; tick;
    rstN = 1'b1;
    tick;
  endtask

  task automatic pulse(input logic [7:0] m);
    reqSet = m;
    tick;
    reqSet = '0;
  endtask

  task automatic finishHandler;
    handlerDone = 1'b1;
    tick;
    handlerDone = 1'b0;
  endtask

  task automatic doStack(input bit verbose, input int injAt, input logic [7:0] injMask);
    for (int k = 0; k < 8; k++) begin
      if (verbose) begin
        chk("R2 pushReq", int'(pushReq), 1);
        chk("R2 wordIdx", int'(wordIdx), k);
      end
      stackDone = 1'b1;
      reqSet = (k == injAt) ? injMask : 8'h00;
      tick;
    end
    stackDone = 1'b0;
    reqSet = '0;
    chk("R3 handlerStart", int'(handlerStart), 1);
  endtask

  task automatic doPop(input bit verbose);
    for (int k = 0; k < 8; k++) begin
      if (verbose) begin
        chk("R10 popReq", int'(popReq), 1);
        chk("R10 wordIdx", int'(wordIdx), 7 - k);
      end
      stackDone = 1'b1;
      tick;
    end
    stackDone = 1'b0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary;
    $finish;
  end

  initial begin
    setPrio(0);
    doReset;

    // R1 / R12 reset state
    chk("R1 pushReq", int'(pushReq), 0);
    chk("R1 popReq", int'(popReq), 0);
    chk("R1 handlerStart", int'(handlerStart), 0);
    chk("R1 depth", int'(depth), 0);
    chk("R12 activeValid idle", int'(activeValid), 0);

    // R4 selection table
    for (int v = 0; v < 8; v++) begin
      doReset;
      pulse(VECS[v][10:3]);
      tick;
      doStack(0, -1, 8'h00);
      chk("R4 winner", int'(activeExc), int'(VECS[v][2:0]));
      chk("R3 depth", int'(depth), 1);
    end

    // R2 / R3 / R10 / R12 single entry and exit
    doReset;
    pulse(8'h20);
    tick;
    chk("R2 pushReq", int'(pushReq), 1);
    tick; tick;
    chk("R2 stall wordIdx", int'(wordIdx), 0);
    chk("R12 activeValid stacking", int'(activeValid), 0);
    doStack(1, -1, 8'h00);
    chk("R3 activeExc", int'(activeExc), 5);
    chk("R12 activeValid handler", int'(activeValid), 1);
    tick;
    chk("R3 strobe width", int'(handlerStart), 0);
    finishHandler;
    chk("R3 pending cleared, pop", int'(popReq), 1);
    doPop(1);
    chk("R10 depth", int'(depth), 0);
    chk("R10 idle activeValid", int'(activeValid), 0);
    tick;
    chk("R3 no re-entry", int'(pushReq), 0);

    // R5 / R9 equal and lower priority stay pending, then chain
    doReset;
    pulse(8'h02);
    tick;
    doStack(0, -1, 8'h00);
    pulse(8'h28);
    tick;
    chk("R5 no push", int'(pushReq), 0);
    chk("R5 activeExc", int'(activeExc), 1);
    chk("R5 depth", int'(depth), 1);
    finishHandler;
    chk("R9 no pop", int'(popReq), 0);
    chk("R12 chain cycle", int'(activeValid), 0);
    tick;
    chk("R9 start", int'(handlerStart), 1);
    chk("R9 activeExc", int'(activeExc), 3);
    chk("R9 depth", int'(depth), 1);
    finishHandler;
    tick;
    chk("R9 second chain", int'(activeExc), 5);
    finishHandler;
    chk("R10 pop", int'(popReq), 1);
    doPop(0);
    chk("R10 depth", int'(depth), 0);

    // R7 late arrival during save
    doReset;
    pulse(8'h01);
    tick;
    doStack(0, 5, 8'h10);
    chk("R7 activeExc", int'(activeExc), 4);
    chk("R7 depth", int'(depth), 1);
    finishHandler;
    chk("R9 no pop", int'(popReq), 0);
    tick;
    chk("R7 displaced chained", int'(activeExc), 0);
    chk("R9 start", int'(handlerStart), 1);
    finishHandler;
    doPop(0);
    chk("R10 depth", int'(depth), 0);

    // R8 / R6 / R10 arrival at the last word
    doReset;
    pulse(8'h01);
    tick;
    doStack(0, 6, 8'h10);
    chk("R8 activeExc", int'(activeExc), 0);
    chk("R8 depth", int'(depth), 1);
    tick;
    chk("R6 preempt push", int'(pushReq), 1);
    doStack(0, -1, 8'h00);
    chk("R6 activeExc", int'(activeExc), 4);
    chk("R6 depth", int'(depth), 2);
    finishHandler;
    chk("R10 pop", int'(popReq), 1);
    doPop(1);
    chk("R10 resume activeExc", int'(activeExc), 0);
    chk("R10 resume depth", int'(depth), 1);
    chk("R10 resume valid", int'(activeValid), 1);
    chk("R10 no start", int'(handlerStart), 0);
    finishHandler;
    doPop(0);
    chk("R10 idle depth", int'(depth), 0);

    // R11 nesting limit
    doReset;
    setPrio(1);
    pulse(8'h01);
    tick;
    doStack(0, -1, 8'h00);
    for (int lvl = 1; lvl < 4; lvl++) begin
      pulse(8'(1 << lvl));
      tick;
      doStack(0, -1, 8'h00);
    end
    chk("R11 depth full", int'(depth), 4);
    pulse(8'h10);
    tick;
    chk("R11 no push", int'(pushReq), 0);
    chk("R11 activeExc", int'(activeExc), 3);
    finishHandler;
    tick;
    chk("R9 chain at full depth", int'(activeExc), 4);
    chk("R9 depth kept", int'(depth), 4);
    finishHandler;
    doPop(0);
    chk("R10 resume activeExc", int'(activeExc), 2);
    chk("R10 resume depth", int'(depth), 3);
    setPrio(0);

    summary;
    $finish;
  end

endmodule